// File: doc/BRIEF.md
# Complex Mixer Datapath with Saturation

The block mixes a stream of 12-bit I/Q sample pairs with cosine and sine values that an external oscillator supplies. First it applies a programmable DC correction to each input lane. It then forms four signed products and reduces each one to 12 bits, either by round-half-to-even or by truncation. The products are combined into complex sums, optionally doubled, and given a second DC correction on the way out. Every addition and every reduction clamps to the 12-bit full-scale range of +2047 / -2048.

The block has two mixing modes. In complex mode the second coefficient pair is derived internally from the first, so the two lanes together form a true complex multiply of (XI + jXQ) by (cos + j sin). In high-speed mode the XI lane is the even-time sample and uses the first coefficient pair. The XQ lane is the odd-time sample and uses the second pair. An adder-clear control routes the raw even-time products to the symbol outputs in place of the sums. The gain stage removes a redundant sign bit once the carrier has been taken out. The pipeline accepts one sample per clock. All control inputs are static and are read every cycle.

Top module: `cmix_datapath`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is 0 and all six data outputs are 0 until the first sample arrives.
- R2: A sample presented with valid_i high appears on the outputs with valid_o high exactly three rising clock edges later. The outputs hold their value while no new sample arrives.
- R3: Before mixing, each input lane is corrected as sat(xi_i + dci_in_i) and sat(xq_i + dcq_in_i), clamped to [-2048, 2047].
- R4: The four products are prod_ie_o = XI*cos_a, prod_qe_o = XI*sin_a, prod_io_o = XQ*sin_b', prod_qo_o = XQ*cos_b'. Each product is reduced by dropping its 11 low bits, where XI and XQ are the corrected inputs and cos_b'/sin_b' are the effective second coefficient pair.
- R5: With rnd_en_i = 1, the 11-bit fraction rounds to nearest. An exact half (fraction 1024) rounds up only when the kept integer part is odd.
- R6: With rnd_en_i = 0, the fraction is discarded, so the result is the floor of product/2048.
- R7: A reduced product that exceeds the 12-bit range clamps. For example, (-2048)*(-2048) gives 2047.
- R8: With hs_mode_i = 0 (complex mode), cos_b_i and sin_b_i have no effect. In this mode cos_b' = cos_a_i and sin_b' = sat(-sin_a_i), so -(-2048) becomes 2047.
- R9: With hs_mode_i = 1 (high-speed mode), cos_b' = cos_b_i and sin_b' = sin_b_i.
- R10: With add_clr_i = 0, the symbol lanes before gain are sat(prod_ie + prod_io) and sat(prod_qe + prod_qo).
- R11: With add_clr_i = 1, the symbol lanes before gain are prod_ie and prod_qe.
- R12: With gain_en_i = 1, each symbol lane is doubled and clamped to [-2048, 2047]. With gain_en_i = 0 the lane passes through unchanged.
- R13: After the gain stage, sym_i_o = sat(lane_i + dci_out_i) and sym_q_o = sat(lane_q + dcq_out_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| xi_i | input | 12 | XI sample (in-phase, or even-time in high-speed mode) |
| xq_i | input | 12 | XQ sample (quadrature, or odd-time in high-speed mode) |
| cos_a_i | input | 12 | First cosine coefficient |
| sin_a_i | input | 12 | First sine coefficient |
| cos_b_i | input | 12 | Second cosine coefficient (high-speed mode only) |
| sin_b_i | input | 12 | Second sine coefficient (high-speed mode only) |
| hs_mode_i | input | 1 | 0 = complex mode, 1 = high-speed mode |
| rnd_en_i | input | 1 | 1 = round-half-to-even, 0 = truncate |
| gain_en_i | input | 1 | Enable the saturating 2x gain |
| add_clr_i | input | 1 | Pass the even-time products in place of the sums |
| dci_in_i | input | 12 | DC correction added to XI before mixing |
| dcq_in_i | input | 12 | DC correction added to XQ before mixing |
| dci_out_i | input | 12 | DC correction added to the I symbol |
| dcq_out_i | input | 12 | DC correction added to the Q symbol |
| valid_o | output | 1 | Output valid |
| prod_ie_o | output | 12 | Reduced product XI*cos_a |
| prod_qe_o | output | 12 | Reduced product XI*sin_a |
| prod_io_o | output | 12 | Reduced product XQ*sin_b' |
| prod_qo_o | output | 12 | Reduced product XQ*cos_b' |
| sym_i_o | output | 12 | I symbol output |
| sym_q_o | output | 12 | Q symbol output |

## Verification
The mixing path is tried with three kinds of input:
- Mid-range complex samples with deliberately wrong second coefficients. These separate complex mode from high-speed mode.
- Products whose fraction lies exactly on, just above, and below one half. These separate round-half-to-even from round-half-up and from truncation, including the floor behaviour for negative products.
- Full-scale corners: -2048 times -2048, sums of two near-full-scale products, doubled large values, and DC corrections that push past the limits. Each corner exposes a stage that wraps instead of clamping.

Adder clear and gain are each tried with values for which the bypassed and non-bypassed results differ.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
  typedef enum logic {
    MODE_COMPLEX = 1'b0,
    MODE_HS      = 1'b1
  } cmix_mode_e;

  localparam int NPROD = 4;
  localparam int P_IE  = 0;
  localparam int P_QE  = 1;
  localparam int P_IO  = 2;
  localparam int P_QO  = 3;
endpackage

// File: rtl/cmix_sat_add.sv
module cmix_sat_add #(
  parameter int W   = 12,
  parameter bit SUB = 1'b0
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0] full;

  generate
    if (SUB) begin : g_sub
      assign full = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    end else begin : g_add
      assign full = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    end
  endgenerate

  always_comb begin
    if (full > MAXV)      y_o = MAXV[W-1:0];
    else if (full < MINV) y_o = MINV[W-1:0];
    else                  y_o = full[W-1:0];
  end
endmodule

// File: rtl/cmix_prod_round.sv
module cmix_prod_round #(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rnd_en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [DW-1:0] p_o
);
  localparam int PW     = DW + CW;
  localparam int SH     = CW - 1;
  localparam int HALF_I = 1 << (SH - 1);
  localparam logic [SH-1:0] HALF = {1'b1, {(SH-1){1'b0}}};
  localparam logic signed [DW+1:0] MAXV = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [DW+1:0] MINV = {3'b111, {(DW-1){1'b0}}};

  logic signed [PW-1:0]   full;
  logic signed [DW:0]     q;
  logic        [SH-1:0]   frac;
  logic                   up;
  logic signed [DW+1:0]   qr;
  logic                   sat;
  logic signed [DW-1:0]   p_d;
  logic signed [PW+1:0]   diff;

  always_comb begin
    full = x_i * c_i;
    q    = full[PW-1:SH];
    frac = full[SH-1:0];
    // exact half goes to the even neighbour
    up   = rnd_en_i && ((frac > HALF) || ((frac == HALF) && q[0]));
    qr   = {q[DW], q} + {{(DW+1){1'b0}}, up};
    sat  = (qr > MAXV) || (qr < MINV);
    if (qr > MAXV)      p_d = MAXV[DW-1:0];
    else if (qr < MINV) p_d = MINV[DW-1:0];
    else                p_d = qr[DW-1:0];
    diff = {{2{full[PW-1]}}, full} - {qr[DW+1], qr, {SH{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= p_d;
  end

  AST_ROUND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rnd_en_i && !sat) |-> (diff >= -HALF_I && diff <= HALF_I)); // R5
  AST_TRUNC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rnd_en_i && !sat) |-> (diff >= 0 && diff < 2 * HALF_I)); // R6
endmodule

// File: rtl/cmix_combine.sv
module cmix_combine #(
  parameter int DW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 add_clr_i,
  input  logic                 gain_en_i,
  input  logic signed [DW-1:0] pe_i [2],
  input  logic signed [DW-1:0] po_i [2],
  input  logic signed [DW-1:0] dco_i [2],
  output logic signed [DW-1:0] sym_o [2]
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW-1:0] sum   [2];
  logic signed [DW-1:0] sel   [2];
  logic signed [DW-1:0] dbl   [2];
  logic signed [DW-1:0] gnd   [2];
  logic signed [DW-1:0] out_c [2];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    cmix_sat_add #(.W(DW), .SUB(1'b0)) u_sum (
      .a_i(pe_i[l]), .b_i(po_i[l]), .y_o(sum[l]));

    assign sel[l] = add_clr_i ? pe_i[l] : sum[l];

    cmix_sat_add #(.W(DW), .SUB(1'b0)) u_dbl (
      .a_i(sel[l]), .b_i(sel[l]), .y_o(dbl[l]));

    assign gnd[l] = gain_en_i ? dbl[l] : sel[l];

    cmix_sat_add #(.W(DW), .SUB(1'b0)) u_dco (
      .a_i(gnd[l]), .b_i(dco_i[l]), .y_o(out_c[l]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sym_o[l] <= '0;
      else if (en_i) sym_o[l] <= out_c[l];
    end

    AST_CLEAR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && add_clr_i && !gain_en_i && dco_i[l] == '0) |-> (out_c[l] == pe_i[l])); // R11
    AST_GAIN_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && gain_en_i && dco_i[l] == '0) |-> (!out_c[l][0] || out_c[l] == MAXV)); // R12
  end
endmodule

// File: rtl/cmix_datapath.sv
module cmix_datapath
  import cmix_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] xi_i,
  input  logic signed [DW-1:0] xq_i,
  input  logic signed [CW-1:0] cos_a_i,
  input  logic signed [CW-1:0] sin_a_i,
  input  logic signed [CW-1:0] cos_b_i,
  input  logic signed [CW-1:0] sin_b_i,
  input  logic                 hs_mode_i,
  input  logic                 rnd_en_i,
  input  logic                 gain_en_i,
  input  logic                 add_clr_i,
  input  logic signed [DW-1:0] dci_in_i,
  input  logic signed [DW-1:0] dcq_in_i,
  input  logic signed [DW-1:0] dci_out_i,
  input  logic signed [DW-1:0] dcq_out_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] prod_ie_o,
  output logic signed [DW-1:0] prod_qe_o,
  output logic signed [DW-1:0] prod_io_o,
  output logic signed [DW-1:0] prod_qo_o,
  output logic signed [DW-1:0] sym_i_o,
  output logic signed [DW-1:0] sym_q_o
);
  localparam int LAT = 3;

  cmix_mode_e mode;
  assign mode = cmix_mode_e'(hs_mode_i);

  logic [LAT-1:0] vld_q;

  logic signed [DW-1:0] xi_c, xq_c, xi_s1, xq_s1;
  logic signed [CW-1:0] sin_neg, cb_c, sb_c;
  logic signed [CW-1:0] ca_s1, sa_s1, cb_s1, sb_s1;

  logic signed [DW-1:0] px   [NPROD];
  logic signed [CW-1:0] pc   [NPROD];
  logic signed [DW-1:0] prod [NPROD];
  logic signed [DW-1:0] prod_q [NPROD];

  logic signed [DW-1:0] pe  [2];
  logic signed [DW-1:0] po  [2];
  logic signed [DW-1:0] dco [2];
  logic signed [DW-1:0] sym [2];

  // stage 1: input DC correction and coefficient selection
  cmix_sat_add #(.W(DW), .SUB(1'b0)) u_dci (.a_i(xi_i), .b_i(dci_in_i), .y_o(xi_c));
  cmix_sat_add #(.W(DW), .SUB(1'b0)) u_dcq (.a_i(xq_i), .b_i(dcq_in_i), .y_o(xq_c));
  cmix_sat_add #(.W(CW), .SUB(1'b1)) u_neg (.a_i('0), .b_i(sin_a_i), .y_o(sin_neg));

  always_comb begin
    if (mode == MODE_HS) begin
      cb_c = cos_b_i;
      sb_c = sin_b_i;
    end else begin
      cb_c = cos_a_i;
      sb_c = sin_neg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xi_s1 <= '0; xq_s1 <= '0;
      ca_s1 <= '0; sa_s1 <= '0; cb_s1 <= '0; sb_s1 <= '0;
    end else if (valid_i) begin
      xi_s1 <= xi_c;    xq_s1 <= xq_c;
      ca_s1 <= cos_a_i; sa_s1 <= sin_a_i;
      cb_s1 <= cb_c;    sb_s1 <= sb_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end

  // stage 2: multiply and reduce
  assign px[P_IE] = xi_s1; assign pc[P_IE] = ca_s1;
  assign px[P_QE] = xi_s1; assign pc[P_QE] = sa_s1;
  assign px[P_IO] = xq_s1; assign pc[P_IO] = sb_s1;
  assign px[P_QO] = xq_s1; assign pc[P_QO] = cb_s1;

  for (genvar k = 0; k < NPROD; k++) begin : g_prod
    cmix_prod_round #(.DW(DW), .CW(CW)) u_mul (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(vld_q[0]), .rnd_en_i(rnd_en_i),
      .x_i(px[k]), .c_i(pc[k]), .p_o(prod[k]));

    // stage 3: align products with symbol outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prod_q[k] <= '0;
      else if (vld_q[1]) prod_q[k] <= prod[k];
    end
  end

  assign pe[0] = prod[P_IE]; assign po[0] = prod[P_IO]; assign dco[0] = dci_out_i;
  assign pe[1] = prod[P_QE]; assign po[1] = prod[P_QO]; assign dco[1] = dcq_out_i;

  cmix_combine #(.DW(DW)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(vld_q[1]),
    .add_clr_i(add_clr_i), .gain_en_i(gain_en_i),
    .pe_i(pe), .po_i(po), .dco_i(dco), .sym_o(sym));

  assign valid_o   = vld_q[LAT-1];
  assign prod_ie_o = prod_q[P_IE];
  assign prod_qe_o = prod_q[P_QE];
  assign prod_io_o = prod_q[P_IO];
  assign prod_qo_o = prod_q[P_QO];
  assign sym_i_o   = sym[0];
  assign sym_q_o   = sym[1];

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q[1] |=> $stable(sym_i_o) && $stable(sym_q_o)); // R2
endmodule

// File: tb/cmix_datapath_bench.sv
module cmix_datapath_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic valid_i = 1'b0;
  logic signed [11:0] xi = '0, xq = '0, ca = '0, sa = '0, cb = '0, sb = '0;
  logic hs = 1'b0, rnd = 1'b1, gain = 1'b0, clr = 1'b0;
  logic signed [11:0] dci = '0, dcq = '0, doi = '0, doq = '0;
  logic valid_o;
  logic signed [11:0] p_ie, p_qe, p_io, p_qo, s_i, s_q;

  int n_run = 0, n_fail = 0;

  cmix_datapath u_cmix_datapath (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .xi_i(xi), .xq_i(xq), .cos_a_i(ca), .sin_a_i(sa), .cos_b_i(cb), .sin_b_i(sb),
    .hs_mode_i(hs), .rnd_en_i(rnd), .gain_en_i(gain), .add_clr_i(clr),
    .dci_in_i(dci), .dcq_in_i(dcq), .dci_out_i(doi), .dcq_out_i(doq),
    .valid_o(valid_o), .prod_ie_o(p_ie), .prod_qe_o(p_qe), .prod_io_o(p_io),
    .prod_qo_o(p_qo), .sym_i_o(s_i), .sym_q_o(s_q));

  function automatic int sat(longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return int'(v);
  endfunction

  function automatic int red(longint p, bit en);
    longint q = p >>> 11;
    longint r = p - q * 2048;
    if (en && (r > 1024 || (r == 1024 && q[0]))) q = q + 1;
    return sat(q);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // run one sample and compare every output against the requirement model
  task automatic run_chk(string tag);
    int exi, exq, ecb, esb, eie, eqe, eio, eqo, li, lq;
    pulse();
    exi = sat(longint'(xi) + dci);
    exq = sat(longint'(xq) + dcq);
    ecb = hs ? int'(cb) : int'(ca);
    esb = hs ? int'(sb) : sat(-longint'(sa));
    eie = red(longint'(exi) * ca, rnd);
    eqe = red(longint'(exi) * sa, rnd);
    eio = red(longint'(exq) * esb, rnd);
    eqo = red(longint'(exq) * ecb, rnd);
    li = clr ? eie : sat(longint'(eie) + eio);
    lq = clr ? eqe : sat(longint'(eqe) + eqo);
    if (gain) begin li = sat(2 * longint'(li)); lq = sat(2 * longint'(lq)); end
    li = sat(longint'(li) + doi);
    lq = sat(longint'(lq) + doq);
    chk({tag, " valid"}, int'(valid_o), 1);
    chk({tag, " prod_ie"}, p_ie, eie);
    chk({tag, " prod_qe"}, p_qe, eqe);
    chk({tag, " prod_io"}, p_io, eio);
    chk({tag, " prod_qo"}, p_qo, eqo);
    chk({tag, " sym_i"}, s_i, li);
    chk({tag, " sym_q"}, s_q, lq);
  endtask

  task automatic defaults();
    hs = 0; rnd = 1; gain = 0; clr = 0;
    dci = 0; dcq = 0; doi = 0; doq = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 sym_i", s_i, 0);
    chk("R1 prod_ie", p_ie, 0);
  endtask

  task automatic t_latency();
    defaults(); xi = 100; xq = 50; ca = 1000; sa = 200; cb = 0; sb = 0;
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    chk("R2 valid after 1 edge", int'(valid_o), 0);
    @(negedge clk);
    chk("R2 valid after 2 edges", int'(valid_o), 0);
    @(negedge clk);
    chk("R2 valid after 3 edges", int'(valid_o), 1);
    @(negedge clk);
    chk("R2 valid single pulse", int'(valid_o), 0);
    chk("R2 hold prod_ie", p_ie, red(100 * 1000, 1));
  endtask

  task automatic t_complex();
    defaults(); xi = 1000; xq = -500; ca = 1500; sa = 700; cb = -1234; sb = 999;
    run_chk("R4 R8 R10 complex");
    sa = -2048; xq = 900;
    run_chk("R8 negate full scale");
    chk("R8 prod_io", p_io, red(900 * 2047, 1));
  endtask

  task automatic t_round();
    defaults(); xq = 0; sa = 0; cb = 0; sb = 0;
    xi = 1; ca = 1024; run_chk("R5 half even down");
    chk("R5 half to 0", p_ie, 0);
    xi = 3; run_chk("R5 half odd up");
    chk("R5 half to 2", p_ie, 2);
    xi = 1; ca = 1025; run_chk("R5 above half");
    chk("R5 up to 1", p_ie, 1);
    xi = -3; ca = 1024; run_chk("R5 negative half");
    chk("R5 -1.5 to -2", p_ie, -2);
  endtask

  task automatic t_trunc();
    defaults(); rnd = 0; xq = 0; sa = 0; cb = 0; sb = 0;
    xi = 3; ca = 1024; run_chk("R6 trunc");
    chk("R6 floor 1.5", p_ie, 1);
    xi = -1; ca = 1; run_chk("R6 trunc negative");
    chk("R6 floor tiny negative", p_ie, -1);
  endtask

  task automatic t_prod_sat();
    defaults(); xi = -2048; ca = -2048; sa = 2047; xq = 0; cb = 0; sb = 0;
    run_chk("R7 product clamp");
    chk("R7 clamp value", p_ie, 2047);
  endtask

  task automatic t_hs();
    defaults(); hs = 1; xi = 1200; xq = -800; ca = 1800; sa = -600; cb = 300; sb = 1700;
    run_chk("R9 high speed");
    chk("R9 prod_qo uses cos_b", p_qo, red(-800 * 300, 1));
  endtask

  task automatic t_add_sat();
    defaults(); xi = 2047; xq = -2048; ca = 2047; sa = 2047; cb = 0; sb = 0;
    run_chk("R10 add clamp");
    chk("R10 sym_i clamp", s_i, 2047);
  endtask

  task automatic t_clear();
    defaults(); clr = 1; xi = 700; xq = 900; ca = 1500; sa = -1100; cb = 0; sb = 0;
    run_chk("R11 adder clear");
    chk("R11 sym_q even", s_q, red(700 * -1100, 1));
  endtask

  task automatic t_gain();
    defaults(); gain = 1; xi = 300; xq = 200; ca = 1400; sa = 500; cb = 0; sb = 0;
    run_chk("R12 gain small");
    xi = 1900; xq = -1900; ca = 1600; sa = 1600;
    run_chk("R12 gain clamp");
    chk("R12 sym_i full scale", s_i, 2047);
  endtask

  task automatic t_dc_in();
    defaults(); xi = 2000; dci = 500; xq = -2000; dcq = -500; ca = 2047; sa = 0; cb = 0; sb = 0;
    run_chk("R3 input dc clamp");
    chk("R3 prod_ie clamped input", p_ie, red(2047 * 2047, 1));
    xi = 100; dci = -300;
    run_chk("R3 input dc plain");
  endtask

  task automatic t_dc_out();
    defaults(); xi = 800; xq = 400; ca = 1000; sa = 900; cb = 0; sb = 0;
    doi = -100; doq = 37;
    run_chk("R13 output dc");
    doi = 2047; doq = -2048; xi = 1500; xq = -1500; ca = 2000; sa = 2000;
    run_chk("R13 output dc clamp");
    chk("R13 sym_i full scale", s_i, 2047);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_complex();
    t_round();
    t_trunc();
    t_prod_sat();
    t_hs();
    t_add_sat();
    t_clear();
    t_gain();
    t_dc_in();
    t_dc_out();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule